// File: doc/BRIEF.md
# Carryless Modular Multiplier over GF(2)

This unit takes two 16-bit polynomials over GF(2) and returns the remainder of their carryless product after division by a 17-bit CRC generator polynomial. A typical use is in a parallel or out-of-order CRC engine. There, the CRC of one chunk is folded into a running total by multiplying it by a precomputed power of x modulo the generator, so that the unit stands in for a run of zero padding.

The reduction does not use a shift-and-subtract division loop. The unit uses three carryless multipliers, each built from AND gates feeding XOR trees:

1. The first multiplier forms the 31-bit product of the operands.
2. The second multiplier scales the upper 15 bits of that product by a fixed reciprocal constant, floor(x^31 / P). The reciprocal is a parameter that is computed offline. Keeping bits 29..15 of this result gives the quotient.
3. The third multiplier multiplies the quotient by P. Its low 16 bits are XORed with the low 16 bits of the product to give the remainder.

A register can be placed after each of the three stages, one parameter bit per stage. The valid flag moves along with the data.

Top module: `gf2_modmul`

## Requirements
- R1: For every operand pair, `rem_out` equals the result of the following 16-step serial procedure. The accumulator starts at 0. Each step shifts the accumulator left by one bit and XORs in 0x1021 when the bit shifted out was 1. It then XORs in A when the current top bit of B is 1, and finally shifts B left by one bit.
- R2: With default parameters the generator is 0x11021 and the reciprocal is 0x8898, so that x^8·x^8 (operands 0x0100 and 0x0100) yields 0x1021.
- R3: In the last stage, bits 30..16 of the quotient times P equal bits 30..16 of the operand product, so the reduction cancels every product bit above x^15.
- R4: When either operand is 0x0000, the remainder is 0x0000.
- R5: When one operand is 0x0001, the remainder equals the other operand.
- R6: `out_valid` equals `in_valid` delayed by the number of enabled stage registers (3 with default parameters), and each stage register's valid copies its input valid from the previous cycle.
- R7: While `rst_n` is low at a clock edge, every enabled stage register clears, so `out_valid` and `rem_out` read 0 on the cycle after reset, even if `in_valid` is held high.
- R8: Operands presented on consecutive cycles each produce their own result, in issue order, one per cycle with no gaps.
- R9: The 31-bit product's bit k is the XOR of a[i]&b[j] over all i+j=k, so multiplying by x^n (a single set bit n) shifts the other operand left by n before reduction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands on op_a/op_b are valid this cycle |
| op_a | input | 16 | First operand polynomial |
| op_b | input | 16 | Second operand polynomial |
| out_valid | output | 1 | rem_out holds a result this cycle |
| rem_out | output | 16 | (op_a·op_b) mod P |

## Verification
Two checks run on every cycle. Each enabled stage register is checked to pass its valid flag forward after exactly one edge. Whenever a quotient is live, the reduction is checked to cancel every product bit above x^15, which is the exactness condition of the reciprocal method. Each multiplier also checks its zero and unit-operand identities on its own inputs. Only the bench scenarios can show end-to-end agreement with the serial procedure, the x^16 corner, result ordering under back-to-back issue, the overall latency, and the reset contents of the output.

// File: rtl/gf2mm_pkg.sv
// Shared constants for the GF(2) modular multiplier.
// Assumes the generator polynomial has its top term at x^OP_W.
package gf2mm_pkg;
    localparam int unsigned DEF_OP_W = 16;
    localparam logic [DEF_OP_W:0]   DEF_GEN   = 17'h11021;
    localparam logic [DEF_OP_W-1:0] DEF_RECIP = 16'h8898;
    localparam int unsigned N_STAGES = 3;
endpackage

// File: rtl/gf2mm_clmul.sv
// Carryless (GF(2)) multiplier, AW-bit by BW-bit, giving an (AW+BW-1)-bit product.
// Each product column is the XOR of the AND terms whose indices sum to that column.
// The XOR reduction is left balanced to synthesis. Purely combinational.
module gf2mm_clmul #(
    parameter int unsigned AW = 16,
    parameter int unsigned BW = 16,
    localparam int unsigned PW = AW + BW - 1
) (
    input  logic [AW-1:0] a,
    input  logic [BW-1:0] b,
    output logic [PW-1:0] p
);
    for (genvar k = 0; k < PW; k++) begin : g_col
        // Reduce all partial products that land in column k.
        always_comb begin
            p[k] = 1'b0;
            for (int i = 0; i < AW; i++) begin
                if ((k - i) >= 0 && (k - i) < BW)
                    p[k] = p[k] ^ (a[i] & b[k - i]);
            end
        end
    end

    // Identity checks on the multiplier's own inputs.
    always_comb begin
        if (!$isunknown(a) && !$isunknown(b)) begin
            if (a == '0)
                assert_zero_gives_zero_R4: assert (p == '0)
                    else $error("clmul: zero operand produced nonzero product");
            if (b == BW'(1))
                assert_unit_keeps_operand_R9: assert (p == PW'(a))
                    else $error("clmul: multiply by one altered operand");
        end
    end
endmodule

// File: rtl/gf2mm_stage.sv
// Optional pipeline register carrying data plus a valid flag.
// EN=0 makes it a plain wire; EN=1 registers both with synchronous active-low reset to zero.
module gf2mm_stage #(
    parameter int unsigned W  = 16,
    parameter bit          EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         v_in,
    input  logic [W-1:0] d_in,
    output logic         v_out,
    output logic [W-1:0] d_out
);
    if (EN) begin : g_reg
        // Capture data and valid each cycle; clear both in reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_out <= 1'b0;
                d_out <= '0;
            end else begin
                v_out <= v_in;
                d_out <= d_in;
            end
        end

        assert_valid_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (v_out == $past(v_in)))
            else $error("stage: valid not delayed by one cycle");
    end else begin : g_wire
        assign v_out = v_in;
        assign d_out = d_in;
    end
endmodule

// File: rtl/gf2_modmul.sv
// (A*B) mod GEN over GF(2) by reciprocal (Barrett) reduction.
// Stage 1: 31-bit product. Stage 2: quotient = ((prod >> W) * RECIP) >> (W-1).
// Stage 3: remainder = prod[W-1:0] ^ (quotient * GEN)[W-1:0].
// Assumes RECIP = floor(x^(2W-1) / GEN), computed offline. STAGE_EN bit i enables a register after stage i+1.
module gf2_modmul
    import gf2mm_pkg::*;
#(
    parameter int unsigned     OP_W     = DEF_OP_W,
    parameter logic [OP_W:0]   GEN      = DEF_GEN,
    parameter logic [OP_W-1:0] RECIP    = DEF_RECIP,
    parameter logic [N_STAGES-1:0] STAGE_EN = 3'b111
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [OP_W-1:0] op_a,
    input  logic [OP_W-1:0] op_b,
    output logic            out_valid,
    output logic [OP_W-1:0] rem_out
);
    localparam int unsigned PW   = 2 * OP_W - 1;   // product width
    localparam int unsigned QW   = OP_W - 1;       // quotient / upper-part width
    localparam int unsigned MTW  = QW + OP_W - 1;  // reciprocal product width
    localparam int unsigned S2W  = PW + QW;

    // Stage 1: operand product.
    logic [PW-1:0] prod0, prod1;
    logic          v1;
    gf2mm_clmul #(.AW(OP_W), .BW(OP_W)) u_mul_ab (.a(op_a), .b(op_b), .p(prod0));
    gf2mm_stage #(.W(PW), .EN(STAGE_EN[0])) u_st1 (
        .clk(clk), .rst_n(rst_n), .v_in(in_valid), .d_in(prod0), .v_out(v1), .d_out(prod1));

    // Stage 2: quotient estimate from the upper product bits.
    logic [MTW-1:0] mt;
    logic [QW-1:0]  quot1, quot2;
    logic [PW-1:0]  prod2;
    logic           v2;
    logic           unused_mt_low;
    gf2mm_clmul #(.AW(QW), .BW(OP_W)) u_mul_recip (.a(prod1[PW-1:OP_W]), .b(RECIP), .p(mt));
    assign quot1 = mt[MTW-1:OP_W-1];
    assign unused_mt_low = ^mt[OP_W-2:0];
    gf2mm_stage #(.W(S2W), .EN(STAGE_EN[1])) u_st2 (
        .clk(clk), .rst_n(rst_n), .v_in(v1), .d_in({prod1, quot1}),
        .v_out(v2), .d_out({prod2, quot2}));

    // Stage 3: fold quotient times generator back into the product.
    logic [PW-1:0]   qp;
    logic [OP_W-1:0] rem3;
    gf2mm_clmul #(.AW(QW), .BW(OP_W + 1)) u_mul_gen (.a(quot2), .b(GEN), .p(qp));
    assign rem3 = prod2[OP_W-1:0] ^ qp[OP_W-1:0];
    gf2mm_stage #(.W(OP_W), .EN(STAGE_EN[2])) u_st3 (
        .clk(clk), .rst_n(rst_n), .v_in(v2), .d_in(rem3), .v_out(out_valid), .d_out(rem_out));

    // Exactness of the reciprocal reduction: upper bits must cancel.
    always_comb begin
        if (rst_n && v2 && !$isunknown(prod2))
            assert_upper_cancels_R3: assert (qp[PW-1:OP_W] == prod2[PW-1:OP_W])
                else $error("modmul: quotient*GEN does not cancel product above x^%0d", OP_W - 1);
    end
endmodule

// File: tb/gf2_modmul_test.sv
module gf2_modmul_test;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] op_a = '0, op_b = '0;
    logic        out_valid;
    logic [15:0] rem_out;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    logic [31:0] seed = 32'h1badc0de;

    gf2_modmul uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a),
                    .op_b(op_b), .out_valid(out_valid), .rem_out(rem_out));

    always #4 clk = ~clk;   // 125 MHz

    // Serial reference from the requirement text.
    function automatic logic [15:0] ref_mod(input logic [15:0] a, input logic [15:0] b);
        logic [15:0] acc = '0;
        logic [15:0] bb = b;
        for (int i = 0; i < 16; i++) begin
            acc = {acc[14:0], 1'b0} ^ (acc[15] ? 16'h1021 : 16'h0000);
            if (bb[15]) acc = acc ^ a;
            bb = {bb[14:0], 1'b0};
        end
        return acc;
    endfunction

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One operation; result sampled LAT cycles later at a falling edge.
    task automatic single(input string req, input logic [15:0] a, input logic [15:0] b,
                          input logic [15:0] exp);
        @(negedge clk);
        op_a = a; op_b = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (LAT - 1) @(negedge clk);
        check({req, " valid"}, 32'(out_valid), 32'd1);
        check(req, 32'(rem_out), 32'(exp));
    endtask

    task automatic test_reset_R7();
        in_valid = 1'b1; op_a = 16'hffff; op_b = 16'hffff;
        repeat (4) @(negedge clk);
        check("R7 out_valid in reset", 32'(out_valid), 32'd0);
        check("R7 rem_out in reset", 32'(rem_out), 32'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 out_valid after reset", 32'(out_valid), 32'd0);
    endtask

    task automatic test_constants_R2();
        single("R2 x^8*x^8", 16'h0100, 16'h0100, 16'h1021);
        single("R2 x^15*x", 16'h8000, 16'h0002, 16'h1021);
    endtask

    task automatic test_zero_R4();
        single("R4 a=0", 16'h0000, 16'hbeef, 16'h0000);
        single("R4 b=0", 16'h1234, 16'h0000, 16'h0000);
    endtask

    task automatic test_unit_R5();
        single("R5 a=1", 16'h0001, 16'hc3a5, 16'hc3a5);
        single("R5 b=1", 16'h7e81, 16'h0001, 16'h7e81);
    endtask

    task automatic test_shift_R9();
        single("R9 x^4 no wrap", 16'h0123, 16'h0010, 16'h1230);
        single("R9 x^15 wrap", 16'h0003, 16'h8000, ref_mod(16'h0003, 16'h8000));
    endtask

    task automatic test_latency_R6();
        @(negedge clk);
        op_a = 16'h5555; op_b = 16'haaaa; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        for (int k = 1; k < LAT; k++) begin
            check("R6 no early valid", 32'(out_valid), 32'd0);
            @(negedge clk);
        end
        check("R6 valid at latency", 32'(out_valid), 32'd1);
        check("R1 value at latency", 32'(rem_out), 32'(ref_mod(16'h5555, 16'haaaa)));
        @(negedge clk);
        check("R6 valid drops", 32'(out_valid), 32'd0);
    endtask

    task automatic test_stream_R8(input int n);
        logic [15:0] qa[$];
        logic [15:0] qb[$];
        for (int c = 0; c < n + LAT; c++) begin
            @(negedge clk);
            if (c >= LAT) begin
                check("R8 stream valid", 32'(out_valid), 32'd1);
                check("R1 R8 stream value", 32'(rem_out), 32'(ref_mod(qa[0], qb[0])));
                void'(qa.pop_front());
                void'(qb.pop_front());
            end
            if (c < n) begin
                seed = next_rand(seed); op_a = seed[15:0];
                seed = next_rand(seed); op_b = seed[15:0];
                qa.push_back(op_a); qb.push_back(op_b);
                in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
        end
    endtask

    task automatic test_patterns_R1();
        single("R1 all ones", 16'hffff, 16'hffff, ref_mod(16'hffff, 16'hffff));
        single("R1 alternating", 16'haaaa, 16'h5555, ref_mod(16'haaaa, 16'h5555));
        single("R1 top bits", 16'h8000, 16'h8000, ref_mod(16'h8000, 16'h8000));
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        test_reset_R7();
        test_constants_R2();
        test_zero_R4();
        test_unit_R5();
        test_shift_R9();
        test_latency_R6();
        test_patterns_R1();
        test_stream_R8(200);
        finish_run();
    end
endmodule